// File: doc/BRIEF.md
# Console I/O word responder

This block answers a processor's programmed I/O transfers addressed to the operator console. It watches the device address, the three-bit function code, the input and output strobes and the active-low instruction-fetch line. When a transfer is addressed to it, it either drives a 16-bit word onto the read side of the data bus, together with a per-bit drive-enable mask, or it captures the word the processor writes.

The block holds a 16-bit entry register loaded from the panel and a 16-bit display register loaded by the processor. It also holds a 4-bit sense register and a one-bit sense-switch latch; the panel and the processor can both load these. One address and function pair has two meanings. During an instruction fetch it returns a console control word, which the processor executes in place of a memory instruction. Otherwise it returns a status word in which only the console's own bits are driven. The control word is assembled from a one-hot target select and a direction flag supplied by the panel.

Bus outputs come from registers. A read word appears one cycle after the strobe is sampled, stays while the strobe is held, and is withdrawn one cycle after the strobe ends.

Top module: `con_io_responder`

## Requirements
- R1: While `rst` is high, and at the first sample after it falls, `bus_rdata`, `bus_oe`, `disp_q`, `sense_q` and `ssw_q` are all zero.
- R2: An input transfer (device address 0, function code 0) with `ifetch_n` low returns a control word. Bits 15..6 hold 0x070. Bits 5..1 copy `pnl_sel[4:0]`, where `pnl_sel[0]` sits at bit 1 (memory), then A, X, I, and P at bit 5. Bit 0 copies `pnl_dir`. All 16 enables are set, giving words such as 0x1C03, 0x1C08, 0x1C04 and 0x1C21.
- R3: If `pnl_sel` has no bit set, or more than one, the control word is the stop word 0x1C00, whatever `pnl_dir` is.
- R4: An input transfer (device address 0, function code 0) with `ifetch_n` high returns the status word. Bit 3 is the sense switch and bits 7..4 hold the sense register, with sense bit 0 at bit 4. `bus_oe` is 0x00F8 and all other data bits read 0.
- R5: An output transfer (device address 0, function code 0) loads the sense switch from bus bit 3 and the sense register from bus bits 7..4. It ignores the other bits and wins over a panel sense load in the same cycle.
- R6: An input transfer with function code 1 returns the sense register on bits 3..0, with zeros above and all enables set. An output transfer with function code 1 changes nothing.
- R7: `pnl_entry_wr` loads `pnl_entry` into the entry register. An input transfer with function code 4 returns that register with all enables set.
- R8: An output transfer with function code 4 loads `bus_wdata` into `disp_q`. No other transfer changes `disp_q`.
- R9: The response to a strobe sampled at one clock edge is visible after that edge and holds while the strobe stays high. After the first edge at which the strobe is low, `bus_oe` and `bus_rdata` return to zero.
- R10: A transfer whose device address is not 0 produces no drive and writes no register.
- R11: `pnl_sense_wr` loads `pnl_sense` and `pnl_ssw` when no function-code-0 output transfer is present in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dev_addr | input | 6 | Device address of the current transfer |
| fcode | input | 3 | Function code of the current transfer |
| io_in | input | 1 | Input strobe (processor reads) |
| io_out | input | 1 | Output strobe (processor writes) |
| ifetch_n | input | 1 | Instruction fetch, active low |
| bus_wdata | input | 16 | Word written by the processor |
| bus_rdata | output | 16 | Word returned to the processor |
| bus_oe | output | 16 | Per-bit drive enable for bus_rdata |
| pnl_entry_wr | input | 1 | Panel load of the entry register |
| pnl_entry | input | 16 | Panel entry value |
| pnl_sense_wr | input | 1 | Panel load of sense register and switch |
| pnl_sense | input | 4 | Panel sense value |
| pnl_ssw | input | 1 | Panel sense-switch value |
| pnl_sel | input | 5 | One-hot target select for the control word |
| pnl_dir | input | 1 | Transfer direction for the control word |
| disp_q | output | 16 | Display holding register |
| sense_q | output | 4 | Sense register |
| ssw_q | output | 1 | Sense-switch latch |

## Verification
A panel load of the sense register and a processor write of the status word can land on the same clock edge, because they come from independent sources. The bench raises `pnl_sense_wr` in the very cycle that carries a function-code-0 output strobe, with different values on each. It then judges the outcome from `sense_q` and `ssw_q`, which must hold the bus value, and from a following status read. A panel-only load afterwards confirms that the panel path still works when nothing competes with it.

// File: rtl/con_io_pkg.sv
package con_io_pkg;
  localparam int DW      = 16;
  localparam int FCW     = 3;
  localparam int SNS_W   = 4;
  localparam int SEL_W   = 5;
  localparam int OPC_W   = DW - SEL_W - 1;

  localparam logic [FCW-1:0] FC_STAT  = 3'd0;
  localparam logic [FCW-1:0] FC_SENSE = 3'd1;
  localparam logic [FCW-1:0] FC_DATA  = 3'd4;

  localparam logic [OPC_W-1:0] CCW_OPC  = 10'h070;
  localparam logic [DW-1:0]    CCW_STOP = 16'h1C00;
  localparam logic [DW-1:0]    STAT_OE  = 16'h00F8;
  localparam int STAT_SSW_BIT = 3;
  localparam int STAT_SNS_LSB = 4;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_RD_CCW,
    OP_RD_STAT,
    OP_WR_STAT,
    OP_RD_SENSE,
    OP_RD_ENTRY,
    OP_WR_DISP
  } io_op_e;
endpackage

// File: rtl/con_io_decode.sv
module con_io_decode
  import con_io_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [FCW-1:0]    fcode,
  input  logic              io_in,
  input  logic              io_out,
  input  logic              ifetch_n,
  output io_op_e            op
);
  logic hit;
  assign hit = (dev_addr == DEV_ADDR);

  always_comb begin
    op = OP_NONE;
    if (hit && io_in && !io_out) begin
      case (fcode)
        FC_STAT:  op = ifetch_n ? OP_RD_STAT : OP_RD_CCW;
        FC_SENSE: op = OP_RD_SENSE;
        FC_DATA:  op = OP_RD_ENTRY;
        default:  op = OP_NONE;
      endcase
    end else if (hit && io_out && !io_in) begin
      case (fcode)
        FC_STAT: op = OP_WR_STAT;
        FC_DATA: op = OP_WR_DISP;
        default: op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/con_ccw_gen.sv
module con_ccw_gen
  import con_io_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  logic             dir,
  output logic [DW-1:0]    ccw
);
  logic [$clog2(SEL_W+1)-1:0] ones;
  logic                       one_hot;

  always_comb begin
    ones = '0;
    for (int i = 0; i < SEL_W; i++) begin
      ones = ones + {{($clog2(SEL_W+1)-1){1'b0}}, sel[i]};
    end
  end

  assign one_hot = (ones == 1);
  assign ccw = one_hot ? {CCW_OPC, sel, dir} : CCW_STOP;
endmodule

// File: rtl/con_io_regs.sv
module con_io_regs
  import con_io_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  io_op_e           op,
  input  logic [DW-1:0]    bus_wdata,
  input  logic             pnl_entry_wr,
  input  logic [DW-1:0]    pnl_entry,
  input  logic             pnl_sense_wr,
  input  logic [SNS_W-1:0] pnl_sense,
  input  logic             pnl_ssw,
  output logic [DW-1:0]    entry_q,
  output logic [DW-1:0]    disp_q,
  output logic [SNS_W-1:0] sense_q,
  output logic             ssw_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      entry_q <= '0;
      disp_q  <= '0;
      sense_q <= '0;
      ssw_q   <= 1'b0;
    end else begin
      if (pnl_entry_wr) entry_q <= pnl_entry;
      if (op == OP_WR_DISP) disp_q <= bus_wdata;
      if (op == OP_WR_STAT) begin
        ssw_q   <= bus_wdata[STAT_SSW_BIT];
        sense_q <= bus_wdata[STAT_SNS_LSB +: SNS_W];
      end else if (pnl_sense_wr) begin
        ssw_q   <= pnl_ssw;
        sense_q <= pnl_sense;
      end
    end
  end
endmodule

// File: rtl/con_io_responder.sv
module con_io_responder
  import con_io_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [FCW-1:0]    fcode,
  input  logic              io_in,
  input  logic              io_out,
  input  logic              ifetch_n,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [DW-1:0]     bus_oe,
  input  logic              pnl_entry_wr,
  input  logic [DW-1:0]     pnl_entry,
  input  logic              pnl_sense_wr,
  input  logic [SNS_W-1:0]  pnl_sense,
  input  logic              pnl_ssw,
  input  logic [SEL_W-1:0]  pnl_sel,
  input  logic              pnl_dir,
  output logic [DW-1:0]     disp_q,
  output logic [SNS_W-1:0]  sense_q,
  output logic              ssw_q
);
  io_op_e        op;
  logic [DW-1:0] ccw;
  logic [DW-1:0] entry_q;
  logic [DW-1:0] word_d;
  logic [DW-1:0] oe_d;

  con_io_decode #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_dec (
    .dev_addr (dev_addr),
    .fcode    (fcode),
    .io_in    (io_in),
    .io_out   (io_out),
    .ifetch_n (ifetch_n),
    .op       (op)
  );

  con_ccw_gen u_ccw (
    .sel (pnl_sel),
    .dir (pnl_dir),
    .ccw (ccw)
  );

  con_io_regs u_regs (
    .clk          (clk),
    .rst          (rst),
    .op           (op),
    .bus_wdata    (bus_wdata),
    .pnl_entry_wr (pnl_entry_wr),
    .pnl_entry    (pnl_entry),
    .pnl_sense_wr (pnl_sense_wr),
    .pnl_sense    (pnl_sense),
    .pnl_ssw      (pnl_ssw),
    .entry_q      (entry_q),
    .disp_q       (disp_q),
    .sense_q      (sense_q),
    .ssw_q        (ssw_q)
  );

  always_comb begin
    word_d = '0;
    oe_d   = '0;
    case (op)
      OP_RD_CCW: begin
        word_d = ccw;
        oe_d   = '1;
      end
      OP_RD_STAT: begin
        word_d[STAT_SSW_BIT]               = ssw_q;
        word_d[STAT_SNS_LSB +: SNS_W]      = sense_q;
        oe_d                               = STAT_OE;
      end
      OP_RD_SENSE: begin
        word_d[SNS_W-1:0] = sense_q;
        oe_d              = '1;
      end
      OP_RD_ENTRY: begin
        word_d = entry_q;
        oe_d   = '1;
      end
      default: begin
        word_d = '0;
        oe_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      bus_oe    <= '0;
    end else begin
      bus_rdata <= word_d;
      bus_oe    <= oe_d;
    end
  end
endmodule

// File: rtl/con_io_responder_chk.sv
module con_io_responder_chk
  import con_io_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter logic [ADDR_W-1:0] DEV_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [FCW-1:0]    fcode,
  input logic              io_in,
  input logic              io_out,
  input logic              ifetch_n,
  input logic [DW-1:0]     bus_rdata,
  input logic [DW-1:0]     bus_oe,
  input logic [DW-1:0]     disp_q
);
  logic rd_hit, wr_hit;
  assign rd_hit = !rst && io_in && !io_out && (dev_addr == DEV_ADDR);
  assign wr_hit = io_out && !io_in && (dev_addr == DEV_ADDR);

  // R9
  drive_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_oe != '0) |-> $past(io_in));

  // R4
  stat_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit && fcode == FC_STAT && ifetch_n) |-> (bus_oe == STAT_OE));

  // R2
  ccw_opcode_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit && fcode == FC_STAT && !ifetch_n)
      |-> (bus_rdata[DW-1:SEL_W+1] == CCW_OPC && bus_oe == '1));

  // R3
  ccw_select_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit && fcode == FC_STAT && !ifetch_n)
      |-> ($onehot0(bus_rdata[SEL_W:1]) && (bus_rdata[SEL_W:1] != '0 || !bus_rdata[0])));

  // R6
  sense_word_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_hit && fcode == FC_SENSE) |-> (bus_rdata[DW-1:SNS_W] == '0));

  // R8
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_hit && fcode == FC_DATA) |-> $stable(disp_q));

  // R10
  foreign_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && dev_addr != DEV_ADDR) |-> (bus_oe == '0));
endmodule

bind con_io_responder con_io_responder_chk #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .dev_addr  (dev_addr),
  .fcode     (fcode),
  .io_in     (io_in),
  .io_out    (io_out),
  .ifetch_n  (ifetch_n),
  .bus_rdata (bus_rdata),
  .bus_oe    (bus_oe),
  .disp_q    (disp_q)
);

// File: tb/con_io_responder_tb.sv
module con_io_responder_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [5:0]  dev_addr;
  logic [2:0]  fcode;
  logic        io_in, io_out, ifetch_n;
  logic [15:0] bus_wdata, bus_rdata, bus_oe;
  logic        pnl_entry_wr;
  logic [15:0] pnl_entry;
  logic        pnl_sense_wr;
  logic [3:0]  pnl_sense;
  logic        pnl_ssw;
  logic [4:0]  pnl_sel;
  logic        pnl_dir;
  logic [15:0] disp_q;
  logic [3:0]  sense_q;
  logic        ssw_q;

  always #10 clk = ~clk;

  con_io_responder u_dut (
    .clk(clk), .rst(rst), .dev_addr(dev_addr), .fcode(fcode),
    .io_in(io_in), .io_out(io_out), .ifetch_n(ifetch_n),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_oe(bus_oe),
    .pnl_entry_wr(pnl_entry_wr), .pnl_entry(pnl_entry),
    .pnl_sense_wr(pnl_sense_wr), .pnl_sense(pnl_sense), .pnl_ssw(pnl_ssw),
    .pnl_sel(pnl_sel), .pnl_dir(pnl_dir),
    .disp_q(disp_q), .sense_q(sense_q), .ssw_q(ssw_q)
  );

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int          due_q[$];
  logic [15:0] expd_q[$];
  logic [15:0] expo_q[$];
  string       tag_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic push(int due, logic [15:0] d, logic [15:0] o, string tag);
    due_q.push_back(due);
    expd_q.push_back(d);
    expo_q.push_back(o);
    tag_q.push_back(tag);
  endtask

  // monitor: pops scoreboard entries when their cycle arrives
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      if (due_q[0] < cyc) begin
        n_chk++;
        n_fail++;
        $display("FAIL %s: actual missed expected due %0d", tag_q[0], due_q[0]);
      end else begin
        check({tag_q[0], " data"}, bus_rdata, expd_q[0]);
        check({tag_q[0], " oe"}, bus_oe, expo_q[0]);
      end
      void'(due_q.pop_front());
      void'(expd_q.pop_front());
      void'(expo_q.pop_front());
      void'(tag_q.pop_front());
    end
  end

  task automatic rd(logic [5:0] addr, logic [2:0] fc, logic ifn,
                    logic [15:0] exp_d, logic [15:0] exp_o, int len, string tag);
    @(negedge clk);
    dev_addr = addr; fcode = fc; ifetch_n = ifn; io_in = 1'b1;
    for (int i = 0; i < len; i++) begin
      push(cyc + 1, exp_d, exp_o, tag);
      @(negedge clk);
    end
    io_in = 1'b0; ifetch_n = 1'b1;
    push(cyc + 1, 16'h0000, 16'h0000, {tag, " release"});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [5:0] addr, logic [2:0] fc, logic [15:0] data);
    @(negedge clk);
    dev_addr = addr; fcode = fc; bus_wdata = data; io_out = 1'b1;
    @(negedge clk);
    io_out = 1'b0;
    @(negedge clk);
  endtask

  task automatic sel_rd(logic [4:0] sel, logic dir, logic [15:0] exp, string tag);
    pnl_sel = sel; pnl_dir = dir;
    rd(6'd0, 3'd0, 1'b0, exp, 16'hFFFF, 1, tag);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; dev_addr = '0; fcode = '0; io_in = 0; io_out = 0; ifetch_n = 1;
    bus_wdata = '0; pnl_entry_wr = 0; pnl_entry = '0; pnl_sense_wr = 0;
    pnl_sense = '0; pnl_ssw = 0; pnl_sel = '0; pnl_dir = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 rdata", bus_rdata, 16'h0);
    check("R1 oe", bus_oe, 16'h0);
    check("R1 disp", disp_q, 16'h0);
    check("R1 sense", {12'h0, sense_q}, 16'h0);
    check("R1 ssw", {15'h0, ssw_q}, 16'h0);

    // R7 panel entry and read
    pnl_entry_wr = 1'b1; pnl_entry = 16'hBEEF;
    @(negedge clk);
    pnl_entry_wr = 1'b0;
    rd(6'd0, 3'd4, 1'b1, 16'hBEEF, 16'hFFFF, 1, "R7 entry");
    // R9 held strobe
    rd(6'd0, 3'd4, 1'b1, 16'hBEEF, 16'hFFFF, 3, "R9 held");

    // R8 display load and hold
    wr(6'd0, 3'd4, 16'hA5C3);
    check("R8 disp load", disp_q, 16'hA5C3);
    rd(6'd0, 3'd4, 1'b1, 16'hBEEF, 16'hFFFF, 1, "R7 reread");
    check("R8 disp after input", disp_q, 16'hA5C3);

    // R5 status write, extra bits ignored
    wr(6'd0, 3'd0, 16'h12A8);
    check("R5 sense", {12'h0, sense_q}, 16'h000A);
    check("R5 ssw", {15'h0, ssw_q}, 16'h0001);
    check("R8 disp after status write", disp_q, 16'hA5C3);

    // R4 status read
    rd(6'd0, 3'd0, 1'b1, 16'h00A8, 16'h00F8, 1, "R4 status");

    // R6 sense read, output ignored
    rd(6'd0, 3'd1, 1'b1, 16'h000A, 16'hFFFF, 1, "R6 sense");
    wr(6'd0, 3'd1, 16'h0055);
    check("R6 sense after fc1 out", {12'h0, sense_q}, 16'h000A);
    check("R6 ssw after fc1 out", {15'h0, ssw_q}, 16'h0001);

    // R2 / R3 control words
    sel_rd(5'b00001, 1'b1, 16'h1C03, "R2 mem in");
    sel_rd(5'b00100, 1'b0, 16'h1C08, "R2 X out");
    sel_rd(5'b10000, 1'b1, 16'h1C21, "R2 P in");
    sel_rd(5'b00010, 1'b0, 16'h1C04, "R2 A out");
    sel_rd(5'b00000, 1'b1, 16'h1C00, "R3 none");
    sel_rd(5'b00011, 1'b1, 16'h1C00, "R3 multi");

    // R10 foreign address
    rd(6'd5, 3'd4, 1'b1, 16'h0000, 16'h0000, 1, "R10 read");
    wr(6'd5, 3'd4, 16'h1111);
    check("R10 disp", disp_q, 16'hA5C3);
    wr(6'd9, 3'd0, 16'h0000);
    check("R10 sense", {12'h0, sense_q}, 16'h000A);

    // R5 / R11 collision: bus write wins
    @(negedge clk);
    dev_addr = 6'd0; fcode = 3'd0; bus_wdata = 16'h0058; io_out = 1'b1;
    pnl_sense_wr = 1'b1; pnl_sense = 4'h3; pnl_ssw = 1'b0;
    @(negedge clk);
    io_out = 1'b0; pnl_sense_wr = 1'b0;
    check("R5 collision sense", {12'h0, sense_q}, 16'h0005);
    check("R5 collision ssw", {15'h0, ssw_q}, 16'h0001);
    rd(6'd0, 3'd0, 1'b1, 16'h0058, 16'h00F8, 1, "R5 collision status");

    // R11 panel alone
    @(negedge clk);
    pnl_sense_wr = 1'b1; pnl_sense = 4'h3; pnl_ssw = 1'b0;
    @(negedge clk);
    pnl_sense_wr = 1'b0;
    check("R11 sense", {12'h0, sense_q}, 16'h0003);
    check("R11 ssw", {15'h0, ssw_q}, 16'h0000);
    rd(6'd0, 3'd1, 1'b1, 16'h0003, 16'hFFFF, 1, "R11 sense read");

    repeat (3) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule